// File: doc/BRIEF.md
# SIMT Warp Issue Sequencer

This block decides which resident warp issues next and spreads that warp's instruction over a narrow row of execution lanes. A warp holds 32 threads that all run the same instruction. The block sends the warp's threads through the lanes in four groups on four consecutive cycles. It therefore makes a new selection only once every fourth clock. By default there are two resident warps (64 threads) and 32 / 4 = 8 lanes. On each cycle of an issue, the lane enables come from the selected warp's active-thread mask. Threads that diverged on a branch therefore keep their lanes off.

A warp can be picked only if it is ready, has at least one active thread and has no thread waiting at a barrier. Selection is round-robin: the search starts at the warp after the one issued last. When no warp qualifies at a selection point, the block spends one four-cycle slot as a bubble with every lane off, then tries again. The active mask is captured at the selection edge, so a mask that changes during an issue does not disturb the lane enables. The datapath and the register-file reads belong to other blocks.

Top module: `simt_issue_seq`

## Requirements
- R1: A warp w is eligible only when warp_ready[w] is 1, its 32-bit slice warp_active[32w+31:32w] is nonzero and its slice warp_bar_wait[32w+31:32w] is zero. Only an eligible warp is ever issued.
- R2: Selection is round-robin. Warps are checked in increasing index order, wrapping around, starting at the warp after the last one that actually issued. The first eligible warp found is taken.
- R3: A selection happens only on the clock edge where lane_group equals 3. issue_warp and issue_valid hold their values while lane_group is 1, 2 or 3.
- R4: lane_group is 0 in the cycle after a selection edge and counts 0, 1, 2, 3 across the four cycles of each slot.
- R5: In the cycle with lane_group = k, lane_en[j] (LANES = 8 bits by default) equals bit 8k+j of the issued warp's active mask.
- R6: The active mask is captured at the selection edge. Changes to warp_active during the slot have no effect on lane_en.
- R7: When no warp is eligible at a selection edge, the slot is a bubble: issue_valid is 0 and lane_en is 0 for all four cycles. Selection is tried again at the end of the slot, and the round-robin pointer is left unchanged.
- R8: rst_n is a synchronous, active-low reset. While it is low, issue_valid is 0, lane_en is 0 and lane_group is 3, so the first edge after release is a selection edge. The pointer is reset so that warp 0 has first priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warp_ready | input | NUM_WARPS | Per-warp ready flag |
| warp_active | input | NUM_WARPS*32 | Per-warp active-thread masks, warp w in bits 32w+31:32w |
| warp_bar_wait | input | NUM_WARPS*32 | Per-warp barrier-wait masks, same layout |
| issue_valid | output | 1 | The current slot carries an instruction (0 = bubble) |
| issue_warp | output | WID_W | Index of the warp being issued |
| lane_group | output | 2 | Which group of 8 threads is on the lanes this cycle |
| lane_en | output | LANES | Per-lane enable for this cycle |

## Verification
The bench targets the following corner cases and the fault each one would expose:
- **Round-robin fairness.** Two always-eligible warps must alternate. A fixed-priority picker would issue warp 0 again and again.
- **Each eligibility condition on its own.** A ready warp with a zero mask, and a ready warp with one thread at a barrier, must both be skipped. A design that tested only the ready flag would issue the wrong warp.
- **Mask changes mid-slot.** The active mask is zeroed partway through an issue, and the lanes must still follow the captured mask. A design that slices the live input would drop lanes.
- **Bubbles and reset.** An empty slot must keep every lane off and retry four cycles later. A reset in the middle of a slot must restart the four-cycle count and give warp 0 priority again. A design with a stale pointer or phase would issue the other warp or put the groups out of step.

// File: rtl/simt_seq_pkg.sv
// Package: shared sizing for the warp issue sequencer.
// Assumes the warp size is an exact multiple of the number of issue cycles.
package simt_seq_pkg;
    localparam int WARP_THREADS = 32;
    localparam int ISSUE_CYCLES = 4;
    localparam int NUM_WARPS    = 2;
    localparam int LANES        = WARP_THREADS / ISSUE_CYCLES;

    // Width of a warp index; never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/warp_elig.sv
// Module: warp_elig
// Builds the per-warp eligibility vector. A warp qualifies when it is ready,
// has at least one active thread and has no thread held at a barrier.
// Assumes flat masks with warp w in bits [w*WT +: WT]. Purely combinational.
module warp_elig #(
    parameter int NW = 2,
    parameter int WT = 32
) (
    input  logic [NW-1:0]    ready,
    input  logic [NW*WT-1:0] active,
    input  logic [NW*WT-1:0] bar_wait,
    output logic [NW-1:0]    elig
);
    for (genvar w = 0; w < NW; w++) begin : g_warp
        // One qualifier per warp: ready, some thread live, none parked.
        assign elig[w] = ready[w] & (|active[w*WT +: WT]) & ~(|bar_wait[w*WT +: WT]);
    end
endmodule

// File: rtl/rr_pick.sv
// Module: rr_pick
// Round-robin picker: scans warps starting one past the last issued index,
// wrapping around, and returns the first eligible one.
// Assumes last < NW. Purely combinational.
module rr_pick #(
    parameter int NW    = 2,
    parameter int WID_W = 1
) (
    input  logic [NW-1:0]    elig,
    input  logic [WID_W-1:0] last,
    output logic             any,
    output logic [WID_W-1:0] winner
);
    // Rotating priority scan: the nearest eligible warp after 'last' wins.
    always_comb begin
        int idx;
        any    = 1'b0;
        winner = '0;
        for (int i = 1; i <= NW; i++) begin
            idx = (int'(last) + i) % NW;
            if (!any && elig[idx]) begin
                any    = 1'b1;
                winner = WID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/issue_ctrl.sv
// Module: issue_ctrl
// Slot controller: counts the issue cycles of a slot, commits a selection on
// the last cycle, captures the winner's active mask and keeps the round-robin
// pointer. Assumes the picker inputs are valid on every selection edge.
module issue_ctrl #(
    parameter int NW    = 2,
    parameter int WT    = 32,
    parameter int IC    = 4,
    parameter int WID_W = 1,
    parameter int PH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_any,
    input  logic [WID_W-1:0] pick_id,
    input  logic [NW*WT-1:0] active,
    output logic [PH_W-1:0]  phase,
    output logic             valid,
    output logic [WID_W-1:0] cur_warp,
    output logic [WT-1:0]    snap,
    output logic [WID_W-1:0] last_issued
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(IC - 1);

    logic sel_edge;
    assign sel_edge = (phase == PH_LAST);

    // Phase counter, selection commit and mask capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_LAST;
            valid       <= 1'b0;
            cur_warp    <= '0;
            snap        <= '0;
            last_issued <= WID_W'(NW - 1);
        end else begin
            phase <= sel_edge ? '0 : phase + 1'b1;
            if (sel_edge) begin
                valid    <= pick_any;
                cur_warp <= pick_id;
                snap     <= pick_any ? active[int'(pick_id)*WT +: WT] : '0;
                if (pick_any) last_issued <= pick_id;
            end
        end
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_LAST) |=> (phase == $past(phase) + 1'b1)); // R4

    AST_HOLD_WARP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_LAST) |=> ($stable(cur_warp) && $stable(valid))); // R3

    AST_BUBBLE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_edge && !pick_any) |=> $stable(last_issued)); // R7
endmodule

// File: rtl/simt_issue_seq.sv
// Module: simt_issue_seq (top)
// Time-multiplexed warp issue: every ISSUE_CYCLES clocks one eligible warp is
// chosen round-robin, and its captured active mask is fed to LANES lanes one
// group per cycle. Assumes inputs are synchronous to clk.
module simt_issue_seq
    import simt_seq_pkg::*;
#(
    parameter int NW    = NUM_WARPS,
    parameter int WT    = WARP_THREADS,
    parameter int IC    = ISSUE_CYCLES,
    parameter int LN    = WT / IC,
    parameter int WID_W = idx_width(NW),
    parameter int PH_W  = idx_width(IC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    warp_ready,
    input  logic [NW*WT-1:0] warp_active,
    input  logic [NW*WT-1:0] warp_bar_wait,
    output logic             issue_valid,
    output logic [WID_W-1:0] issue_warp,
    output logic [PH_W-1:0]  lane_group,
    output logic [LN-1:0]    lane_en
);
    logic [NW-1:0]    elig;
    logic             pick_any;
    logic [WID_W-1:0] pick_id;
    logic [WID_W-1:0] last_issued;
    logic [WT-1:0]    snap;

    warp_elig #(.NW(NW), .WT(WT)) elig_i (
        .ready(warp_ready), .active(warp_active),
        .bar_wait(warp_bar_wait), .elig(elig)
    );

    rr_pick #(.NW(NW), .WID_W(WID_W)) pick_i (
        .elig(elig), .last(last_issued), .any(pick_any), .winner(pick_id)
    );

    issue_ctrl #(.NW(NW), .WT(WT), .IC(IC), .WID_W(WID_W), .PH_W(PH_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .pick_any(pick_any), .pick_id(pick_id),
        .active(warp_active), .phase(lane_group), .valid(issue_valid),
        .cur_warp(issue_warp), .snap(snap), .last_issued(last_issued)
    );

    // Slice the captured mask by the current lane group; gate off bubbles.
    always_comb begin
        lane_en = issue_valid ? snap[int'(lane_group)*LN +: LN] : '0;
    end

    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_group == PH_W'(IC - 1) && pick_any) |-> elig[pick_id]); // R1

    AST_NONE_MEANS_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_group == PH_W'(IC - 1) && elig == '0) |=> !issue_valid); // R7

    AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (lane_en == '0)); // R7
endmodule

// File: tb/simt_issue_seq_tb.sv
// Bench for simt_issue_seq: a vector table of slots, then directed tests for
// mid-slot mask change, mid-slot reset and bubble retry.
module simt_issue_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  rdy;
        logic [31:0] a0;
        logic [31:0] a1;
        logic        bw0;
        logic        bw1;
        logic        ev;
        logic        ew;
    } vec_t;

    // Expected warp/valid worked out by hand from R1, R2, R7 (pointer starts at 1).
    localparam vec_t VECS [0:9] = '{
        '{2'b11, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'b11, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'b11, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'b01, 32'h0F0F_3C3C, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'b11, 32'hFFFF_FFFF, 32'hA5A5_0001, 1'b1, 1'b0, 1'b1, 1'b1},
        '{2'b11, 32'hF0F0_A5A5, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'b11, 32'h0000_00FF, 32'hFF00_0000, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'b11, 32'h8000_0001, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  warp_ready = '0;
    logic [63:0] warp_active = '0;
    logic [63:0] warp_bar_wait = '0;
    logic        issue_valid;
    logic [0:0]  issue_warp;
    logic [1:0]  lane_group;
    logic [7:0]  lane_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simt_issue_seq dut_i (
        .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready),
        .warp_active(warp_active), .warp_bar_wait(warp_bar_wait),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .lane_group(lane_group), .lane_en(lane_en)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Drive one slot from a negedge where the next posedge is a selection edge.
    task automatic run_slot(input vec_t v, input bit alter);
        logic [31:0] m;
        warp_ready    = v.rdy;
        warp_active   = {v.a1, v.a0};
        warp_bar_wait = {(v.bw1 ? 32'h0000_0100 : 32'h0), (v.bw0 ? 32'h0000_0100 : 32'h0)};
        m = v.ew ? v.a1 : v.a0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R4 lane_group", 32'(lane_group), 32'(k));
            chk("R1/R7 issue_valid", 32'(issue_valid), 32'(v.ev));
            if (v.ev) chk("R2/R3 issue_warp", 32'(issue_warp), 32'(v.ew));
            chk(alter ? "R6 lane_en after mask change" : "R5 lane_en",
                32'(lane_en), v.ev ? 32'(m[k*8 +: 8]) : 32'h0);
            if (alter) warp_active = '0;
        end
    endtask

    initial begin
        vec_t v;
        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset issue_valid", 32'(issue_valid), 32'h0);
        chk("R8 reset lane_en", 32'(lane_en), 32'h0);
        chk("R8 reset lane_group", 32'(lane_group), 32'h3);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) run_slot(VECS[i], 1'b0);

        // R6: pointer now at warp 0, so warp 1 issues; mask zeroed mid-slot
        v = '{2'b11, 32'h1111_1111, 32'hC3C3_9966, 1'b0, 1'b0, 1'b1, 1'b1};
        run_slot(v, 1'b1);

        // R8: reset during a slot (warp 0 issuing), then warp 0 first again
        warp_ready = 2'b11;
        warp_active = {32'hFFFF_FFFF, 32'h0000_00FF};
        warp_bar_wait = '0;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        chk("R2 warp before mid reset", 32'(issue_warp), 32'h0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8 mid reset issue_valid", 32'(issue_valid), 32'h0);
        chk("R8 mid reset lane_group", 32'(lane_group), 32'h3);
        rst_n = 1'b1;
        v = '{2'b11, 32'h0000_00FF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0};
        run_slot(v, 1'b0);   // R8 pointer restart

        // R7: bubble then retry picks the now-ready warp
        v = '{2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0};
        run_slot(v, 1'b0);
        v = '{2'b10, 32'hFFFF_FFFF, 32'h00FF_00FF, 1'b0, 1'b0, 1'b1, 1'b1};
        run_slot(v, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule